// File: doc/BRIEF.md
# Multi-Pipe Receive Address Matcher

This block decides which of six logical receive pipes a received frame belongs to by comparing the frame's address field, byte by byte as it arrives, against the programmed pipe addresses. Address bytes enter least-significant byte first. A byte-valid strobe marks each byte, and a frame-start pulse marks the first byte of a frame. When the last address byte has been taken in, the block gives a one-cycle result strobe together with a 3-bit pipe number. The pipe number is the lowest enabled pipe whose address matched, or 3'b111 when none matched.

The address length is selected by a 2-bit width code and can be 3, 4 or 5 bytes. The two primary pipes each have a full 40-bit address. The four secondary pipes store only their own low byte and borrow every higher byte from the second primary pipe. The width code and the pipe enables are captured when a frame starts, so a configuration write during a frame affects only later frames. The address registers must be held stable while a frame is in progress.

Top module: `rx_addr_match`

## Requirements
- R1: After reset `match_valid` is 0 and `match_pipe` is 3'b111.
- R2: Width code `cfg_width` = 2'b01, 2'b10 or 2'b11 selects an address of 3, 4 or 5 bytes. Byte k of a frame (k = 0 is the byte taken with `frame_start`) is compared with bits [8k+7:8k] of the pipe address. `match_valid` is high for exactly the one cycle that follows the clock edge at which the last address byte is accepted.
- R3: Pipes 0 and 1 compare against `cfg_addr_p0` and `cfg_addr_p1`. Only the low width-many bytes take part in the compare, and any higher stored bytes are ignored.
- R4: Pipe n, for n in 2..5, uses byte `cfg_lsb_sec[8(n-2)+7:8(n-2)]` as its address byte 0. Its bytes 1 and up are bytes 1 and up of `cfg_addr_p1`.
- R5: Bit p of `cfg_pipe_en` enables pipe p. A disabled pipe never produces a match, and any combination of pipes may be enabled.
- R6: When several enabled pipes match, `match_pipe` gives the lowest pipe number.
- R7: When no enabled pipe matches, `match_valid` still pulses and `match_pipe` reads 3'b111.
- R8: A frame started while the width code is 2'b00 gives no `match_valid` pulse.
- R9: The width code and the enables are captured at `frame_start`. A change to them later in the same frame has no effect on that frame's result.
- R10: Bytes that arrive with no frame open have no effect and produce no pulse. This covers bytes after reset with no `frame_start` and bytes beyond the last address byte of a frame.
- R11: Whenever `match_valid` is low, `match_pipe` reads 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Marks the first address byte of a frame; also opens the frame |
| byte_valid | input | 1 | The address byte on `byte_data` is valid this cycle |
| byte_data | input | 8 | Received address byte, least-significant byte first |
| cfg_width | input | 2 | Address width code: 01 = 3, 10 = 4, 11 = 5 bytes, 00 illegal |
| cfg_pipe_en | input | 6 | Per-pipe enable, bit p for pipe p |
| cfg_addr_p0 | input | 40 | Full address of pipe 0 |
| cfg_addr_p1 | input | 40 | Full address of pipe 1; its upper bytes are shared with pipes 2 to 5 |
| cfg_lsb_sec | input | 32 | Low address bytes of pipes 2 to 5, pipe 2 in bits [7:0] |
| match_valid | output | 1 | One-cycle result strobe |
| match_pipe | output | 3 | Matched pipe number, 3'b111 when there is no match |

## Verification
Each pipe's running compare flag is internal state. A flag that drops or sticks in error shows up only at the end of a frame, as a wrong pipe number in the single result cycle. Because of this, every frame's result is checked against a model that uses 3, 4 and 5 byte widths and addresses that differ in exactly one byte. A fault in the frame counter or in the captured width moves or removes the result strobe. The bench therefore samples the exact cycle after the last byte and also the cycle after that. The captured-configuration and stray-byte requirements are checked by changing the inputs during a frame and by sending bytes outside a frame, then observing the strobe.

// File: rtl/rxam_pkg.sv
package rxam_pkg;

  typedef logic [1:0] wcode_t;

  // Width code 00 is not a usable address length.
  function automatic logic wcode_legal(input wcode_t c);
    return c != 2'b00;
  endfunction

  // Address length in bytes for a legal width code.
  function automatic int wcode_bytes(input wcode_t c);
    return int'(c) + 2;
  endfunction

endpackage

// File: rtl/rxam_frame_ctl.sv
module rxam_frame_ctl
  import rxam_pkg::*;
#(
  parameter int NUM_PIPES = 6,
  parameter int MAX_BYTES = 5,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_start,
  input  logic                 byte_valid,
  input  wcode_t               cfg_width,
  input  logic [NUM_PIPES-1:0] cfg_pipe_en,
  output logic                 accept,
  output logic [CNT_W-1:0]     idx,
  output logic                 last,
  output logic [NUM_PIPES-1:0] en_eff
);

  logic                 open_q;
  logic [CNT_W-1:0]     cnt_q;
  wcode_t               wid_q;
  logic [NUM_PIPES-1:0] en_q;
  wcode_t               wid_eff;
  logic                 open_eff;

  // On the frame-start cycle the live configuration applies; later bytes use
  // the copy captured at the start.
  always_comb begin
    wid_eff  = frame_start ? cfg_width   : wid_q;
    en_eff   = frame_start ? cfg_pipe_en : en_q;
    open_eff = frame_start ? wcode_legal(cfg_width) : open_q;
    idx      = frame_start ? '0 : cnt_q;
    accept   = byte_valid && open_eff;
    last     = accept && (int'(idx) == wcode_bytes(wid_eff) - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
      wid_q  <= 2'b00;
      en_q   <= '0;
    end else begin
      if (frame_start) begin
        wid_q  <= cfg_width;
        en_q   <= cfg_pipe_en;
        open_q <= wcode_legal(cfg_width);
        cnt_q  <= '0;
      end
      if (accept) begin
        cnt_q <= idx + 1'b1;
        if (last) open_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rxam_byte_cmp.sv
module rxam_byte_cmp #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 5,
  localparam int ADDR_W = BYTE_W * MAX_BYTES,
  localparam int CNT_W  = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              first,
  input  logic              accept,
  input  logic [CNT_W-1:0]  idx,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [ADDR_W-1:0] pipe_addr,
  output logic              hit_now
);

  logic              alive_q;
  logic [BYTE_W-1:0] ref_byte;
  logic              eq;

  always_comb begin
    ref_byte = '0;
    for (int b = 0; b < MAX_BYTES; b++) begin
      if (int'(idx) == b) ref_byte = pipe_addr[b*BYTE_W +: BYTE_W];
    end
    eq      = (ref_byte == byte_in);
    hit_now = (first ? 1'b1 : alive_q) && eq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alive_q <= 1'b0;
    end else if (accept) begin
      alive_q <= hit_now;
    end else if (first) begin
      alive_q <= 1'b1;
    end
  end

endmodule

// File: rtl/rxam_prio_enc.sv
module rxam_prio_enc #(
  parameter int NUM_PIPES = 6,
  localparam int PIPE_W = $clog2(NUM_PIPES + 1)
) (
  input  logic [NUM_PIPES-1:0] hits,
  output logic                 any,
  output logic [PIPE_W-1:0]    code
);

  always_comb begin
    any  = |hits;
    code = '1;
    for (int p = NUM_PIPES - 1; p >= 0; p--) begin
      if (hits[p]) code = PIPE_W'(p);
    end
  end

endmodule

// File: rtl/rx_addr_match.sv
module rx_addr_match
  import rxam_pkg::*;
#(
  parameter int NUM_PIPES = 6,
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 5,
  localparam int ADDR_W = BYTE_W * MAX_BYTES,
  localparam int SEC_W  = BYTE_W * (NUM_PIPES - 2),
  localparam int PIPE_W = $clog2(NUM_PIPES + 1),
  localparam int CNT_W  = $clog2(MAX_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_start,
  input  logic                 byte_valid,
  input  logic [BYTE_W-1:0]    byte_data,
  input  logic [1:0]           cfg_width,
  input  logic [NUM_PIPES-1:0] cfg_pipe_en,
  input  logic [ADDR_W-1:0]    cfg_addr_p0,
  input  logic [ADDR_W-1:0]    cfg_addr_p1,
  input  logic [SEC_W-1:0]     cfg_lsb_sec,
  output logic                 match_valid,
  output logic [PIPE_W-1:0]    match_pipe
);

  logic                 accept;
  logic                 last;
  logic [CNT_W-1:0]     idx;
  logic [NUM_PIPES-1:0] en_eff;
  logic [NUM_PIPES-1:0] hit_now;
  logic [NUM_PIPES-1:0] hit_en;
  logic [ADDR_W-1:0]    pipe_addr [NUM_PIPES];
  logic                 any_hit;
  logic [PIPE_W-1:0]    hit_code;

  rxam_frame_ctl #(
    .NUM_PIPES(NUM_PIPES),
    .MAX_BYTES(MAX_BYTES)
  ) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .byte_valid (byte_valid),
    .cfg_width  (cfg_width),
    .cfg_pipe_en(cfg_pipe_en),
    .accept     (accept),
    .idx        (idx),
    .last       (last),
    .en_eff     (en_eff)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PIPES; p++) begin : g_pipe
      if (p == 0) begin : g_full0
        assign pipe_addr[p] = cfg_addr_p0;
      end else if (p == 1) begin : g_full1
        assign pipe_addr[p] = cfg_addr_p1;
      end else begin : g_shared
        assign pipe_addr[p] = {cfg_addr_p1[ADDR_W-1:BYTE_W],
                               cfg_lsb_sec[(p-2)*BYTE_W +: BYTE_W]};
      end

      rxam_byte_cmp #(
        .BYTE_W   (BYTE_W),
        .MAX_BYTES(MAX_BYTES)
      ) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .first    (frame_start),
        .accept   (accept),
        .idx      (idx),
        .byte_in  (byte_data),
        .pipe_addr(pipe_addr[p]),
        .hit_now  (hit_now[p])
      );
    end
  endgenerate

  assign hit_en = hit_now & en_eff;

  rxam_prio_enc #(
    .NUM_PIPES(NUM_PIPES)
  ) u_enc (
    .hits(hit_en),
    .any (any_hit),
    .code(hit_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_valid <= 1'b0;
      match_pipe  <= '1;
    end else begin
      match_valid <= last;
      match_pipe  <= (last && any_hit) ? hit_code : '1;
    end
  end

endmodule

// File: rtl/rxam_chk.sv
module rxam_chk #(
  parameter int NUM_PIPES = 6,
  localparam int PIPE_W = $clog2(NUM_PIPES + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 frame_start,
  input logic                 byte_valid,
  input logic [1:0]           cfg_width,
  input logic [NUM_PIPES-1:0] cfg_pipe_en,
  input logic                 match_valid,
  input logic [PIPE_W-1:0]    match_pipe
);

  logic [NUM_PIPES-1:0] en_seen;
  logic [1:0]           wid_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_seen  <= '0;
      wid_seen <= 2'b00;
    end else if (frame_start) begin
      en_seen  <= cfg_pipe_en;
      wid_seen <= cfg_width;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!match_valid && match_pipe == '1));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    match_valid |=> !match_valid);

  p_follows_byte_r2: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> $past(byte_valid));

  p_enabled_only_r5: assert property (@(posedge clk) disable iff (rst)
    (match_valid && match_pipe != '1) |-> en_seen[match_pipe]);

  p_no_illegal_r8: assert property (@(posedge clk) disable iff (rst)
    match_valid |-> (wid_seen != 2'b00));

  p_idle_code_r11: assert property (@(posedge clk) disable iff (rst)
    !match_valid |-> (match_pipe == '1));

endmodule

bind rx_addr_match rxam_chk #(.NUM_PIPES(NUM_PIPES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_start(frame_start),
  .byte_valid (byte_valid),
  .cfg_width  (cfg_width),
  .cfg_pipe_en(cfg_pipe_en),
  .match_valid(match_valid),
  .match_pipe (match_pipe)
);

// File: tb/rx_addr_match_tb.sv
`timescale 1ns/1ps
module rx_addr_match_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [1:0]  cfg_width = 2'b11;
  logic [5:0]  cfg_pipe_en = '0;
  logic [39:0] cfg_addr_p0 = '0;
  logic [39:0] cfg_addr_p1 = '0;
  logic [31:0] cfg_lsb_sec = '0;
  logic        match_valid;
  logic [2:0]  match_pipe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rx_addr_match u_dut (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .cfg_width  (cfg_width),
    .cfg_pipe_en(cfg_pipe_en),
    .cfg_addr_p0(cfg_addr_p0),
    .cfg_addr_p1(cfg_addr_p1),
    .cfg_lsb_sec(cfg_lsb_sec),
    .match_valid(match_valid),
    .match_pipe (match_pipe)
  );

  function automatic logic [39:0] addr_of(input int p);
    if (p == 0) return cfg_addr_p0;
    if (p == 1) return cfg_addr_p1;
    return {cfg_addr_p1[39:8], cfg_lsb_sec[(p-2)*8 +: 8]};
  endfunction

  // Expected {valid, pipe} for a frame, from the requirements.
  function automatic logic [3:0] model(input logic [39:0] data,
                                       input logic [1:0] w,
                                       input logic [5:0] en);
    logic [39:0] mask;
    if (w == 2'b00) return 4'b0111;
    mask = (40'd1 << (8 * (int'(w) + 2))) - 40'd1;
    for (int p = 0; p < 6; p++) begin
      if (en[p] && ((addr_of(p) & mask) == (data & mask))) return {1'b1, 3'(p)};
    end
    return 4'b1111;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual valid/pipe=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives n bytes on falling edges; returns at the falling edge after the last byte.
  task automatic send_frame(input logic [39:0] data, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_start = (i == 0);
      byte_valid  = 1'b1;
      byte_data   = data[8*i +: 8];
    end
    @(negedge clk);
    frame_start = 1'b0;
    byte_valid  = 1'b0;
  endtask

  task automatic frame_check(input string req, input logic [39:0] data);
    logic [3:0] exp;
    int n;
    exp = model(data, cfg_width, cfg_pipe_en);
    n = (cfg_width == 2'b00) ? 3 : int'(cfg_width) + 2;
    send_frame(data, n);
    check(req, {match_valid, match_pipe}, exp);
    @(negedge clk);
    check({req, "_R2_pulse"}, {match_valid, match_pipe}, 4'b0111);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {match_valid, match_pipe}, 4'b0111);
    rst = 1'b0;

    cfg_addr_p0 = 40'hA1_B2_C3_D4_E5;
    cfg_addr_p1 = 40'h11_22_33_44_55;
    cfg_lsb_sec = 32'h99_88_77_66;
    cfg_pipe_en = 6'b111111;

    // R10: bytes with no open frame after reset
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = 8'hE5;
      @(posedge clk); #1;
      check("R10_no_frame", {match_valid, match_pipe}, 4'b0111);
    end
    @(negedge clk); byte_valid = 1'b0;

    // R2/R3: each width on primary pipes
    cfg_width = 2'b11; frame_check("R2_R3_w5_p0", cfg_addr_p0);
    cfg_width = 2'b10; frame_check("R2_R3_w4_p1", cfg_addr_p1);
    cfg_width = 2'b01; frame_check("R2_R3_w3_p0", cfg_addr_p0);
    // R3: upper byte differs but lies above the width
    cfg_width = 2'b01; frame_check("R3_upper_ignored", {16'hFFFF, cfg_addr_p0[23:0]});
    cfg_width = 2'b11; frame_check("R3_top_byte_diff", {8'h00, cfg_addr_p0[31:0]});
    // R4: secondary pipes
    for (int p = 2; p < 6; p++) begin
      cfg_width = 2'b11;
      frame_check("R4_secondary", addr_of(p));
    end
    // R4: secondary low byte with wrong upper bytes
    frame_check("R4_upper_from_p1", {32'hDEADBEEF, cfg_lsb_sec[7:0]});
    // R5: disabled pipe
    cfg_pipe_en = 6'b111011; frame_check("R5_disabled", addr_of(2));
    cfg_pipe_en = 6'b000000; frame_check("R5_none_enabled", cfg_addr_p0);
    cfg_pipe_en = 6'b111111;
    // R6: p0 and p3 share an address
    cfg_addr_p0 = {cfg_addr_p1[39:8], cfg_lsb_sec[15:8]};
    frame_check("R6_lowest", cfg_addr_p0);
    cfg_pipe_en = 6'b111110; frame_check("R6_next_lowest", cfg_addr_p0);
    cfg_pipe_en = 6'b111111;
    cfg_addr_p0 = 40'hA1_B2_C3_D4_E5;
    // R7: no match
    frame_check("R7_no_match", 40'h01_02_03_04_07);
    // R8: illegal width
    cfg_width = 2'b00; frame_check("R8_illegal", cfg_addr_p0);

    // R9: width and enables change mid-frame
    cfg_width = 2'b01; cfg_pipe_en = 6'b000001;
    @(negedge clk); frame_start = 1'b1; byte_valid = 1'b1; byte_data = cfg_addr_p0[7:0];
    @(negedge clk); frame_start = 1'b0; byte_data = cfg_addr_p0[15:8];
    cfg_width = 2'b11; cfg_pipe_en = 6'b000000;
    @(negedge clk); byte_data = cfg_addr_p0[23:16];
    @(negedge clk); byte_valid = 1'b0;
    check("R9_captured_cfg", {match_valid, match_pipe}, 4'b1000);

    // R10: bytes past the end of a width-3 frame
    cfg_width = 2'b01; cfg_pipe_en = 6'b111111;
    send_frame(cfg_addr_p1, 3);
    check("R10_frame_end", {match_valid, match_pipe}, 4'b1001);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_data = cfg_addr_p1[8*(3+(i%2)) +: 8];
      @(posedge clk); #1;
      check("R10_extra_bytes", {match_valid, match_pipe}, 4'b0111);
    end
    @(negedge clk); byte_valid = 1'b0;

    // Random frames
    for (int t = 0; t < 300; t++) begin
      logic [39:0] d;
      int sel;
      cfg_addr_p0 = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      cfg_addr_p1 = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      cfg_lsb_sec = $urandom;
      if ($urandom_range(3) == 0) cfg_lsb_sec[15:8] = cfg_lsb_sec[7:0];
      cfg_pipe_en = 6'($urandom);
      cfg_width   = ($urandom_range(9) == 0) ? 2'b00 : 2'($urandom_range(3, 1));
      sel = $urandom_range(7);
      d = (sel < 6) ? addr_of(sel) : ({$urandom, $urandom} & 40'hFF_FFFF_FFFF);
      if ($urandom_range(3) == 0) d[8*$urandom_range(4) +: 8] ^= 8'h01;
      frame_check("R2_R3_R4_R5_R6_R7_R8_rand", d);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule